// File: doc/BRIEF.md
# Paced Multi-Channel DAC Sample Sequencer

This block feeds a bank of four DAC channel output registers from a 1024-entry sample queue that the host fills through a small register port. Each queued sample is handed to one channel. A programmable channel window, given by a first and a last channel index, decides which channels receive samples. The scanner visits the channels of the window in ascending order and then returns to the first one.

A transfer is started by one of two sources. In paced mode each strobe from an external timer moves one sample. In direct mode each host write to a command address moves exactly one sample. Status flags report whether the queue holds data and where its fill level stands against the half-way mark. A sticky flag records a pacer strobe that found the queue empty, and a second sticky flag records a host write that the full queue dropped. An interrupt line follows the half-full condition and has an active-low enable.

In simultaneous mode, incoming samples are parked in staging registers. All four outputs are then loaded in the same cycle when the scanner reaches the last channel of the window.

Top module: `dac_pace_seq`

## Requirements
- R1: A write to address 0 queues the sample held in `wdata[15:4]`, with bit 15 as the sample MSB. `wdata[3:0]` is ignored. Each output channel c appears on `dac_value[12c+11:12c]`.
- R2: Control is written at address 1 and read back there: lo = bits [1:0], hi = bits [3:2], simul = bit 4, run = bit 5, irq_off = bit 6. A control write resets the channel pointer to lo. Each transfer loads the channel under the pointer, and `dac_load` pulses that channel's bit for one cycle. The pointer then advances by one, or returns to lo after hi.
- R3: When hi < lo, every transfer goes to channel lo only.
- R4: Status is read at address 0. Status bit 0 is 1 when the queue holds at least one sample and 0 when it is empty.
- R5: Status bit 1 is 1 while the queue holds 512 samples or fewer, and 0 when it holds more than 512.
- R6: Status bit 3 is 1 while the queue holds 512 samples or more. Output `irq` equals status bit 3 while irq_off is 0 and stays 0 while irq_off is 1.
- R7: With run = 1, each cycle with `pacer_tick` high moves one sample. With run = 0, `pacer_tick` has no effect.
- R8: With run = 0, each write to address 2 moves exactly one sample. With run = 1, writes to address 2 have no effect.
- R9: With simul = 1, transfers update only the staging registers. The transfer to the hi channel loads all four outputs at once, and `dac_load` is then all ones.
- R10: A pacer strobe with run = 1 and an empty queue sets status bit 2 and leaves every output unchanged. Bit 2 stays set until the next control write. A direct command on an empty queue does not set it.
- R11: A write to address 0 while the queue holds 1024 samples is dropped and sets status bit 4. Bit 4 stays set until the next control write.
- R12: After reset, all outputs are 0, `dac_load` is 0, `irq` is 0, and status reads 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for `addr` |
| pacer_tick | input | 1 | One-cycle strobe from the external timer |
| dac_value | output | 48 | Four 12-bit channel output registers |
| dac_load | output | 4 | Per-channel update strobe |
| irq | output | 1 | Half-full interrupt request |

## Verification
The embedded assertions check properties on every cycle. The pointer must stay inside the effective window and must return to the first channel after the last one. Transfers to a reversed window must land on the low channel. Outputs must hold in any cycle without a transfer. Each transfer must load one channel, or all four in simultaneous mode. The two error flags must stay set, and the queue count must stay bounded and hold when a write hits a full queue.

Only the bench's scenarios can show the remaining behaviours. These are that sample values travel in order to the right channels, that the exact 512 and 1024 thresholds hold, that the interrupt mask works, and that pacer strobes and direct commands are each ignored in the wrong mode.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned SMP_W  = 12;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NCH    = 4;
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_FIFO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd2;

  typedef struct packed {
    logic            irq_off;
    logic            run;
    logic            simul;
    logic [CH_W-1:0] hi;
    logic [CH_W-1:0] lo;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dps_sample_fifo.sv
module dps_sample_fifo #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned W     = 12,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_nxt, rp_q, rp_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_nxt  = wp_q;
    rp_nxt  = rp_q;
    cnt_nxt = cnt_q;
    if (do_push) wp_nxt = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_nxt = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_nxt = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      wp_q  <= wp_nxt;
      rp_q  <= rp_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_W'(DEPTH)); // R11
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (full && push && !pop) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/dps_chan_scan.sv
module dps_chan_scan
  import dps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [CH_W-1:0] lo_new,
  input  logic [CH_W-1:0] lo_cur,
  input  logic [CH_W-1:0] hi_cur,
  input  logic            step,
  output logic [CH_W-1:0] ptr,
  output logic            at_top
);
  logic [CH_W-1:0] ptr_q, ptr_nxt, hi_eff;
  logic            ptr_en;

  assign hi_eff = (hi_cur < lo_cur) ? lo_cur : hi_cur;
  assign at_top = (ptr_q == hi_eff);
  assign ptr    = ptr_q;
  assign ptr_en = cfg_load | step;

  always_comb begin
    ptr_nxt = ptr_q;
    if (cfg_load)  ptr_nxt = lo_new;
    else if (step) ptr_nxt = at_top ? lo_cur : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (ptr_q >= lo_cur) && (ptr_q <= hi_eff)); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step && !cfg_load && at_top) |=> (ptr_q == $past(lo_cur))); // R2
  AST_REVERSED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (hi_cur < lo_cur) |-> (ptr_q == lo_cur)); // R3
endmodule

// File: rtl/dps_dac_bank.sv
module dps_dac_bank
  import dps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [CH_W-1:0]      ch,
  input  logic [SMP_W-1:0]     sample,
  input  logic                 simul,
  input  logic                 flush,
  output logic [NCH*SMP_W-1:0] dac_value,
  output logic [NCH-1:0]       dac_load
);
  logic [SMP_W-1:0] stage_q [NCH];
  logic [SMP_W-1:0] stage_nxt [NCH];
  logic [SMP_W-1:0] out_q [NCH];
  logic [SMP_W-1:0] out_nxt [NCH];
  logic [NCH-1:0]   load_q, load_nxt;

  always_comb begin
    stage_nxt = stage_q;
    out_nxt   = out_q;
    load_nxt  = '0;
    if (wr) begin
      stage_nxt[ch] = sample;
      if (!simul) begin
        out_nxt[ch]  = sample;
        load_nxt[ch] = 1'b1;
      end else if (flush) begin
        out_nxt  = stage_nxt;
        load_nxt = '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        stage_q[i] <= '0;
        out_q[i]   <= '0;
      end
      load_q <= '0;
    end else begin
      load_q <= load_nxt;
      if (wr) begin
        stage_q <= stage_nxt;
        out_q   <= out_nxt;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign dac_value[g*SMP_W +: SMP_W] = out_q[g];
  end
  assign dac_load = load_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr |=> ($stable(dac_value) && dac_load == '0)); // R10
  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr && !simul) |=> $onehot(dac_load)); // R2
  AST_SIMUL_ALL: assert property (@(posedge clk) disable iff (!rst_n) (wr && simul) |=> (dac_load == '0 || dac_load == '1)); // R9
endmodule

// File: rtl/dac_pace_seq.sv
module dac_pace_seq
  import dps_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  input  logic                 pacer_tick,
  output logic [NCH*SMP_W-1:0] dac_value,
  output logic [NCH-1:0]       dac_load,
  output logic                 irq
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned HALF  = FIFO_DEPTH / 2;

  logic [1:0]       rsync_q;
  logic             rst_i_n;
  ctrl_t            ctrl_q, ctrl_nxt, ctrl_wr_val;
  logic             ctrl_wr, data_wr, cmd_wr;
  logic             xfer_req, pop, underrun_set;
  logic             underrun_q, underrun_nxt, ovf_q, ovf_nxt, flag_en;
  logic [SMP_W-1:0] head;
  logic [CNT_W-1:0] count;
  logic             empty, full;
  logic [CH_W-1:0]  ptr;
  logic             at_top;
  logic             below_half, irq_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign ctrl_wr     = wr_en && (addr == A_CTRL);
  assign data_wr     = wr_en && (addr == A_FIFO);
  assign cmd_wr      = wr_en && (addr == A_CMD);
  assign ctrl_wr_val = ctrl_t'(wdata[CTRL_W-1:0]);

  assign xfer_req     = !ctrl_wr && (ctrl_q.run ? pacer_tick : cmd_wr);
  assign pop          = xfer_req && !empty;
  assign underrun_set = xfer_req && ctrl_q.run && empty;

  always_comb begin
    ctrl_nxt     = ctrl_wr ? ctrl_wr_val : ctrl_q;
    underrun_nxt = ctrl_wr ? 1'b0 : (underrun_q | underrun_set);
    ovf_nxt      = ctrl_wr ? 1'b0 : (ovf_q | (data_wr & full));
    flag_en      = ctrl_wr | underrun_set | (data_wr & full);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q     <= '0;
      underrun_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_nxt;
      if (flag_en) begin
        underrun_q <= underrun_nxt;
        ovf_q      <= ovf_nxt;
      end
    end
  end

  dps_sample_fifo #(.DEPTH(FIFO_DEPTH), .W(SMP_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (data_wr),
    .pop   (pop),
    .wdata (wdata[WORD_W-1 -: SMP_W]),
    .rdata (head),
    .count (count),
    .empty (empty),
    .full  (full)
  );

  dps_chan_scan u_scan (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cfg_load (ctrl_wr),
    .lo_new   (ctrl_wr_val.lo),
    .lo_cur   (ctrl_q.lo),
    .hi_cur   (ctrl_q.hi),
    .step     (pop),
    .ptr      (ptr),
    .at_top   (at_top)
  );

  dps_dac_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr        (pop),
    .ch        (ptr),
    .sample    (head),
    .simul     (ctrl_q.simul),
    .flush     (at_top),
    .dac_value (dac_value),
    .dac_load  (dac_load)
  );

  assign below_half = (count <= CNT_W'(HALF));
  assign irq_stat   = (count >= CNT_W'(HALF));
  assign irq        = irq_stat & ~ctrl_q.irq_off;

  always_comb begin
    rdata = '0;
    case (addr)
      A_FIFO:  rdata = WORD_W'({ovf_q, irq_stat, underrun_q, below_half, ~empty});
      A_CTRL:  rdata = WORD_W'(ctrl_q);
      default: rdata = '0;
    endcase
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n) (underrun_q && !ctrl_wr) |=> underrun_q); // R10
  AST_NO_UNDERRUN_DIRECT: assert property (@(posedge clk) disable iff (!rst_i_n) (!ctrl_q.run && !ctrl_wr) |=> (underrun_q == $past(underrun_q))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n) (ovf_q && !ctrl_wr) |=> ovf_q); // R11
endmodule

// File: tb/dac_pace_seq_tb.sv
module dac_pace_seq_tb;
  import dps_pkg::*;
  localparam int DEPTH = 1024;
  localparam int HALF  = 512;

  logic                 clk, rst_n, wr_en, pacer_tick, irq;
  logic [ADDR_W-1:0]    addr;
  logic [WORD_W-1:0]    wdata, rdata;
  logic [NCH*SMP_W-1:0] dac_value;
  logic [NCH-1:0]       dac_load;

  dac_pace_seq u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pacer_tick(pacer_tick), .dac_value(dac_value),
    .dac_load(dac_load), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit mon_on = 0;
  bit finished = 0;

  // reference model
  logic [SMP_W-1:0] mq[$];
  logic [SMP_W-1:0] m_stage [NCH];
  logic [SMP_W-1:0] m_out [NCH];
  logic [CH_W-1:0]  m_lo, m_hi, m_ptr;
  bit m_simul, m_run, m_irqoff, m_unr, m_ovf;
  logic [NCH-1:0]       exp_load_q[$];
  logic [NCH*SMP_W-1:0] exp_val_q[$];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NCH*SMP_W-1:0] pack_out();
    logic [NCH*SMP_W-1:0] p;
    for (int c = 0; c < NCH; c++) p[c*SMP_W +: SMP_W] = m_out[c];
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] exp_status();
    int n = mq.size();
    return {11'd0, m_ovf, (n >= HALF), m_unr, (n <= HALF), (n != 0)};
  endfunction

  task automatic m_xfer();
    logic [CH_W-1:0] he;
    logic [SMP_W-1:0] v;
    if (mq.size() == 0) begin
      if (m_run) m_unr = 1;
      return;
    end
    v  = mq.pop_front();
    he = (m_hi < m_lo) ? m_lo : m_hi;
    m_stage[m_ptr] = v;
    if (!m_simul) begin
      m_out[m_ptr] = v;
      exp_load_q.push_back(NCH'(1) << m_ptr);
      exp_val_q.push_back(pack_out());
    end else if (m_ptr == he) begin
      for (int c = 0; c < NCH; c++) m_out[c] = m_stage[c];
      exp_load_q.push_back('1);
      exp_val_q.push_back(pack_out());
    end
    m_ptr = (m_ptr == he) ? m_lo : m_ptr + 1'b1;
  endtask

  function automatic logic [WORD_W-1:0] cw(int lo, int hi, bit simul, bit run, bit irqoff);
    return WORD_W'({irqoff, run, simul, 2'(hi), 2'(lo)});
  endfunction

  // driver: called at a falling edge, returns at the next falling edge
  task automatic wr_reg(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    if (a == A_FIFO) begin
      if (mq.size() < DEPTH) mq.push_back(d[WORD_W-1 -: SMP_W]);
      else m_ovf = 1;
    end else if (a == A_CTRL) begin
      m_lo = d[1:0]; m_hi = d[3:2]; m_simul = d[4]; m_run = d[5]; m_irqoff = d[6];
      m_ptr = m_lo; m_unr = 0; m_ovf = 0;
    end else if (a == A_CMD) begin
      if (!m_run) m_xfer();
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    pacer_tick = 1'b1;
    if (m_run) m_xfer();
    @(negedge clk);
    pacer_tick = 1'b0;
  endtask

  task automatic rd_status(string tag);
    logic [WORD_W-1:0] e;
    addr = A_FIFO;
    #1;
    e = exp_status();
    chk(rdata == e, tag, "status", rdata, e);
    chk(irq == (e[3] & ~m_irqoff), "R6", "irq", irq, e[3] & ~m_irqoff);
  endtask

  task automatic chk_out(string tag);
    chk(dac_value == pack_out(), tag, "dac_value", dac_value, pack_out());
  endtask

  // monitor: scoreboard comparison of every channel update
  always @(negedge clk) begin
    if (mon_on && dac_load != '0) begin
      if (exp_load_q.size() == 0) begin
        chk(0, "R2", "unexpected load", dac_load, 0);
      end else begin
        logic [NCH-1:0] el;
        logic [NCH*SMP_W-1:0] ev;
        el = exp_load_q.pop_front();
        ev = exp_val_q.pop_front();
        chk(dac_load == el, "R2", "load mask", dac_load, el);
        chk(dac_value == ev, "R1", "dac_value on load", dac_value, ev);
      end
    end
  end

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    rst_n = 0; wr_en = 0; addr = '0; wdata = '0; pacer_tick = 0;
    m_lo = 0; m_hi = 0; m_ptr = 0; m_simul = 0; m_run = 0; m_irqoff = 0; m_unr = 0; m_ovf = 0;
    for (int c = 0; c < NCH; c++) begin m_stage[c] = '0; m_out[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    mon_on = 1;

    // R12 reset state
    chk(dac_value == '0, "R12", "dac_value", dac_value, 0);
    chk(dac_load == '0, "R12", "dac_load", dac_load, 0);
    chk(irq == 1'b0, "R12", "irq", irq, 0);
    addr = A_FIFO; #1;
    chk(rdata == 16'h0002, "R12", "status", rdata, 16'h0002);
    @(negedge clk);

    // R1/R2 window 1..2, direct mode, junk in low nibble
    wr_reg(A_CTRL, cw(1, 2, 0, 0, 0));
    addr = A_CTRL; #1;
    chk(rdata == cw(1, 2, 0, 0, 0), "R2", "ctrl readback", rdata, cw(1, 2, 0, 0, 0));
    @(negedge clk);
    for (int i = 0; i < 4; i++) wr_reg(A_FIFO, {12'hA10 + 12'(i), 4'hF});
    rd_status("R4");
    for (int i = 0; i < 4; i++) wr_reg(A_CMD, '0);
    rd_status("R4");
    chk_out("R2");

    // R3 reversed window
    wr_reg(A_CTRL, cw(2, 0, 0, 0, 0));
    for (int i = 0; i < 2; i++) wr_reg(A_FIFO, {12'h3C0 + 12'(i), 4'h9});
    for (int i = 0; i < 2; i++) wr_reg(A_CMD, '0);
    chk_out("R3");

    // R7 tick ignored in direct mode, R8 direct transfer
    wr_reg(A_CTRL, cw(0, 3, 0, 0, 0));
    wr_reg(A_FIFO, {12'h777, 4'h0});
    tick();
    rd_status("R7");
    chk_out("R7");
    wr_reg(A_CMD, '0);
    rd_status("R8");

    // R7 paced, R8 command ignored while running
    wr_reg(A_CTRL, cw(0, 3, 0, 1, 0));
    for (int i = 0; i < 5; i++) wr_reg(A_FIFO, {12'h500 + 12'(i * 17), 4'h3});
    wr_reg(A_CMD, '0);
    rd_status("R8");
    chk_out("R8");
    for (int i = 0; i < 5; i++) begin
      tick();
      @(negedge clk);
    end
    rd_status("R7");
    chk_out("R7");

    // R10 underrun
    tick();
    rd_status("R10");
    chk_out("R10");
    tick();
    rd_status("R10");
    wr_reg(A_CTRL, cw(0, 3, 0, 1, 0));
    rd_status("R10");
    wr_reg(A_CTRL, cw(0, 3, 0, 0, 0));
    wr_reg(A_CMD, '0);
    rd_status("R10");

    // R9 simultaneous update
    wr_reg(A_CTRL, cw(0, 3, 1, 0, 0));
    for (int i = 0; i < 4; i++) wr_reg(A_FIFO, {12'hC00 + 12'(i * 3), 4'h1});
    for (int i = 0; i < 3; i++) wr_reg(A_CMD, '0);
    chk_out("R9");
    wr_reg(A_CMD, '0);
    chk_out("R9");
    wr_reg(A_CTRL, cw(1, 2, 1, 1, 0));
    for (int i = 0; i < 2; i++) wr_reg(A_FIFO, {12'h0F0 + 12'(i), 4'h2});
    tick();
    chk_out("R9");
    tick();
    chk_out("R9");

    // R5/R6/R11 thresholds and overflow
    wr_reg(A_CTRL, cw(0, 0, 0, 0, 0));
    for (int i = 0; i < HALF - 1; i++) wr_reg(A_FIFO, {12'(i), 4'h5});
    rd_status("R5");
    wr_reg(A_FIFO, {12'(HALF - 1), 4'h5});
    rd_status("R6");
    wr_reg(A_CTRL, cw(0, 0, 0, 0, 1));
    rd_status("R6");
    wr_reg(A_FIFO, {12'(HALF), 4'h5});
    rd_status("R5");
    for (int i = HALF + 1; i < DEPTH; i++) wr_reg(A_FIFO, {12'(i), 4'h5});
    rd_status("R11");
    wr_reg(A_FIFO, {12'hABC, 4'h5});
    rd_status("R11");
    for (int i = 0; i < DEPTH; i++) wr_reg(A_CMD, '0);
    rd_status("R11");
    chk_out("R11");
    wr_reg(A_CTRL, cw(0, 0, 0, 0, 0));
    rd_status("R11");

    repeat (2) @(negedge clk);
    chk(exp_load_q.size() == 0, "R2", "pending expected loads", exp_load_q.size(), 0);
    finish_sim();
  end
endmodule